// File: doc/BRIEF.md
# Multi-Camera Row Concatenation Gatherer

This block takes several camera pixel streams that run side by side and turns them into one very wide output frame. Each output row is the same row number from every camera, placed one after another. Camera 0 comes first and the highest-numbered camera comes last. The inputs are never interleaved pixel by pixel and never tiled into a grid. The output is one frame whose width is the number of cameras times the camera line width. With the default parameters that is five cameras of 752 pixels each, giving a 3760-pixel row, with 480 rows per frame.

Each camera writes 8-bit grayscale pixels into its own line FIFO. The FIFO stores every pixel together with the camera's frame-start flag and counts how many complete lines it holds. A sequencer waits until every camera holds at least one complete line. It then reads one camera's line after another, one pixel per clock, and drives the output valid, frame-start and end-of-line markers. The cameras are expected to be frame-aligned to within one line time, and the frame height follows the cameras' own frame-start flags. A pixel that arrives at a full FIFO is dropped, and a per-camera error flag is set and held until software clears it.

At one output pixel per clock, a clock of about 150 MHz gives the 150 Mpixel/s aggregate rate that five cameras need.

Top module: `camgather_top`

## Requirements
- R1: An output row carries camera 0's buffered line, then camera 1's, and so on up to camera NUM_CAM-1. Within each camera's part, pixels appear in the order they arrived.
- R2: No output row starts, and no FIFO is read, until every camera holds at least one complete line. A complete line is one whose final pixel was accepted with `cam_eol` set.
- R3: `out_eol` is high on output pixel NUM_CAM*LINE_W-1 of each row (pixel 11 in a 3-camera, 4-pixel configuration) and low on every other pixel.
- R4: `out_sof` is high only on pixel 0 of a row, and only when camera 0's first pixel of that line arrived with `cam_sof` high.
- R5: Once a row has started, all NUM_CAM*LINE_W pixels come out on consecutive clocks, with `out_valid` held high throughout. At most one FIFO is read per clock.
- R6: A pixel presented to a full FIFO is dropped and sets bit c of `cam_err` for that camera c. The other bits are unchanged.
- R7: A set `cam_err` bit stays set until `err_clr` is high for a clock, which clears every bit. A new overflow in the same clock as `err_clr` wins.
- R8: After reset, `out_valid`, `out_sof` and `out_eol` are low, `cam_err` is zero and all FIFOs are empty. The first row after reset therefore carries only pixels written after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for inputs and output |
| rst | input | 1 | Synchronous reset, active high |
| cam_valid | input | NUM_CAM | Pixel strobe, one bit per camera |
| cam_data | input | NUM_CAM*PIX_W | Pixel values, camera c in bits [c*PIX_W +: PIX_W] |
| cam_sof | input | NUM_CAM | Frame-start flag on a camera's first pixel of a frame |
| cam_eol | input | NUM_CAM | Set on a camera's last pixel of a line |
| err_clr | input | 1 | Clears all overflow flags |
| out_valid | output | 1 | Output pixel strobe |
| out_data | output | PIX_W | Output pixel value |
| out_sof | output | 1 | First pixel of the first row of a frame |
| out_eol | output | 1 | Last pixel of a combined row |
| cam_err | output | NUM_CAM | Sticky overflow flag for each camera |

## Verification
If a FIFO's complete-line count drifts, the next row starts too early or stalls. The early start shows within a row time as a read of an empty FIFO, or as stale pixel values in one camera's part of the output. A wrong camera or pixel index shows on the first affected output pixel: the data arrives out of order, or `out_eol` lands on the wrong pixel. A lost overflow flag, or one set on the wrong camera, is visible on `cam_err` one clock after the dropped write.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_SEND = 1'b1} seq_state_t;

  function automatic int row_pixels(input int n_cam, input int line_w);
    return n_cam * line_w;
  endfunction

  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gather_line_fifo.sv
module gather_line_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             wr_eol,
  input  logic             rd_en,
  input  logic             line_take,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             line_ready,
  output logic             ovf
);
  localparam int AW = gather_pkg::idx_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill, lines;
  logic             full, wr_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
  assign wr_ok = wr_en && !full;
  assign ovf   = wr_en && full;
  assign head  = mem[rd_ptr];
  assign line_ready = (lines != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      lines  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      fill  <= fill + CW'(wr_ok) - CW'(rd_en);
      lines <= lines + CW'(wr_ok && wr_eol) - CW'(line_take);
    end
  end
endmodule

// File: rtl/gather_sequencer.sv
module gather_sequencer #(
  parameter int NUM_CAM = 5,
  parameter int LINE_W  = 752
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic [NUM_CAM-1:0]                           line_ready,
  output logic [NUM_CAM-1:0]                           pop,
  output logic [NUM_CAM-1:0]                           line_take,
  output logic [gather_pkg::idx_bits(NUM_CAM)-1:0]     cam_idx,
  output logic                                         row_first,
  output logic                                         row_last,
  output logic                                         busy,
  output logic                                         all_ready
);
  import gather_pkg::*;
  localparam int CB = idx_bits(NUM_CAM);
  localparam int PB = idx_bits(LINE_W);

  seq_state_t    state;
  logic [PB-1:0] pix_idx;
  logic          cam_last, pix_last;

  assign all_ready = &line_ready;
  assign busy      = (state == SEQ_SEND);
  assign pix_last  = (pix_idx == PB'(LINE_W - 1));
  assign cam_last  = (cam_idx == CB'(NUM_CAM - 1));
  assign row_first = busy && (cam_idx == '0) && (pix_idx == '0);
  assign row_last  = busy && cam_last && pix_last;

  for (genvar c = 0; c < NUM_CAM; c++) begin : g_pop
    assign pop[c]       = busy && (cam_idx == CB'(c));
    assign line_take[c] = pop[c] && pix_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      cam_idx <= '0;
      pix_idx <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          cam_idx <= '0;
          pix_idx <= '0;
          if (all_ready) state <= SEQ_SEND;
        end
        SEQ_SEND: begin
          if (pix_last) begin
            pix_idx <= '0;
            if (cam_last) begin
              cam_idx <= '0;
              state   <= SEQ_IDLE;
            end else begin
              cam_idx <= cam_idx + 1'b1;
            end
          end else begin
            pix_idx <= pix_idx + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gather_err_flags.sv
module gather_err_flags #(
  parameter int NUM_CAM = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CAM-1:0] set,
  input  logic               clr,
  output logic [NUM_CAM-1:0] flags
);
  for (genvar c = 0; c < NUM_CAM; c++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[c] <= 1'b0;
      else if (set[c]) flags[c] <= 1'b1;
      else if (clr)    flags[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/camgather_top.sv
module camgather_top #(
  parameter int NUM_CAM = 5,
  parameter int LINE_W  = 752,
  parameter int PIX_W   = 8,
  parameter int DEPTH   = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CAM-1:0]         cam_valid,
  input  logic [NUM_CAM*PIX_W-1:0]   cam_data,
  input  logic [NUM_CAM-1:0]         cam_sof,
  input  logic [NUM_CAM-1:0]         cam_eol,
  input  logic                       err_clr,
  output logic                       out_valid,
  output logic [PIX_W-1:0]           out_data,
  output logic                       out_sof,
  output logic                       out_eol,
  output logic [NUM_CAM-1:0]         cam_err
);
  localparam int CB = gather_pkg::idx_bits(NUM_CAM);
  localparam int WW = PIX_W + 1;

  logic [NUM_CAM-1:0] fifo_empty, line_ready, fifo_ovf, pop, line_take;
  logic [WW-1:0]      head_word [NUM_CAM];
  logic [CB-1:0]      cam_idx;
  logic               row_first, row_last, seq_busy, all_ready;
  logic [WW-1:0]      sel_word;

  for (genvar c = 0; c < NUM_CAM; c++) begin : g_cam
    gather_line_fifo #(.WIDTH(WW), .DEPTH(DEPTH)) u_fifo (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (cam_valid[c]),
      .wr_word    ({cam_sof[c], cam_data[c*PIX_W +: PIX_W]}),
      .wr_eol     (cam_eol[c]),
      .rd_en      (pop[c]),
      .line_take  (line_take[c]),
      .head       (head_word[c]),
      .empty      (fifo_empty[c]),
      .line_ready (line_ready[c]),
      .ovf        (fifo_ovf[c])
    );
  end

  gather_sequencer #(.NUM_CAM(NUM_CAM), .LINE_W(LINE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .line_ready (line_ready),
    .pop        (pop),
    .line_take  (line_take),
    .cam_idx    (cam_idx),
    .row_first  (row_first),
    .row_last   (row_last),
    .busy       (seq_busy),
    .all_ready  (all_ready)
  );

  gather_err_flags #(.NUM_CAM(NUM_CAM)) u_err (
    .clk   (clk),
    .rst   (rst),
    .set   (fifo_ovf),
    .clr   (err_clr),
    .flags (cam_err)
  );

  always_comb begin
    sel_word = head_word[0];
    for (int c = 0; c < NUM_CAM; c++) begin
      if (cam_idx == CB'(c)) sel_word = head_word[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      out_valid <= seq_busy;
      out_data  <= sel_word[PIX_W-1:0];
      out_sof   <= row_first && sel_word[PIX_W];
      out_eol   <= row_last;
    end
  end
endmodule

// File: rtl/camgather_chk.sv
module camgather_chk #(
  parameter int NUM_CAM = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CAM-1:0] pop,
  input logic [NUM_CAM-1:0] fifo_empty,
  input logic [NUM_CAM-1:0] fifo_ovf,
  input logic               seq_busy,
  input logic               all_ready,
  input logic               out_valid,
  input logic               out_sof,
  input logic               out_eol,
  input logic [NUM_CAM-1:0] cam_err,
  input logic               err_clr
);
  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(pop)); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst) (pop & fifo_empty) == '0); // R2
  AST_START_READY: assert property (@(posedge clk) disable iff (rst) $rose(seq_busy) |-> $past(all_ready)); // R2
  AST_BUSY_EMITS: assert property (@(posedge clk) disable iff (rst) seq_busy |=> out_valid); // R5
  AST_SOF_VALID: assert property (@(posedge clk) disable iff (rst) out_sof |-> out_valid); // R4
  AST_EOL_VALID: assert property (@(posedge clk) disable iff (rst) out_eol |-> out_valid); // R3
  AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (rst) (|fifo_ovf) |=> ((cam_err & $past(fifo_ovf)) == $past(fifo_ovf))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) !err_clr |=> ((cam_err & $past(cam_err)) == $past(cam_err))); // R7
endmodule

bind camgather_top camgather_chk #(.NUM_CAM(NUM_CAM)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pop        (pop),
  .fifo_empty (fifo_empty),
  .fifo_ovf   (fifo_ovf),
  .seq_busy   (seq_busy),
  .all_ready  (all_ready),
  .out_valid  (out_valid),
  .out_sof    (out_sof),
  .out_eol    (out_eol),
  .cam_err    (cam_err),
  .err_clr    (err_clr)
);

// File: tb/test_camgather_top.sv
module test_camgather_top;
  localparam int N   = 3;
  localparam int LW  = 4;
  localparam int PW  = 8;
  localparam int DP  = 8;
  localparam int ROW = N * LW;
  localparam logic [N-1:0] ALL = '1;

  // entry: [15:8] seed, [7] frame start, [2:0] cameras fed first
  localparam logic [15:0] VEC [5] = '{
    {8'h10, 1'b1, 4'h0, 3'b111},
    {8'h20, 1'b0, 4'h0, 3'b001},
    {8'h40, 1'b0, 4'h0, 3'b100},
    {8'h60, 1'b1, 4'h0, 3'b011},
    {8'h80, 1'b0, 4'h0, 3'b000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] cam_valid = '0, cam_sof = '0, cam_eol = '0;
  logic [N*PW-1:0] cam_data = '0;
  logic err_clr = 1'b0;
  logic out_valid, out_sof, out_eol;
  logic [PW-1:0] out_data;
  logic [N-1:0] cam_err;

  int errors = 0, checks = 0, cyc = 0, obs_cnt = 0;
  bit done = 0;
  logic [PW-1:0] obs_data [256];
  logic obs_sof [256], obs_eol [256];
  int obs_cyc [256];

  always #10 clk = ~clk;

  camgather_top #(.NUM_CAM(N), .LINE_W(LW), .PIX_W(PW), .DEPTH(DP)) i_camgather_top (
    .clk(clk), .rst(rst), .cam_valid(cam_valid), .cam_data(cam_data),
    .cam_sof(cam_sof), .cam_eol(cam_eol), .err_clr(err_clr),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol), .cam_err(cam_err)
  );

  always @(negedge clk) begin
    cyc++;
    if (out_valid && obs_cnt < 256) begin
      obs_data[obs_cnt] = out_data;
      obs_sof[obs_cnt]  = out_sof;
      obs_eol[obs_cnt]  = out_eol;
      obs_cyc[obs_cnt]  = cyc;
      obs_cnt++;
    end
  end

  function automatic logic [PW-1:0] exp_pix(input logic [7:0] seed, input int cam, input int p);
    return seed + 8'(cam * 16) + 8'(p);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic feed(input logic [N-1:0] mask, input logic [7:0] seed, input bit sof);
    if (mask != '0) begin
      for (int p = 0; p < LW; p++) begin
        @(negedge clk);
        for (int c = 0; c < N; c++) begin
          cam_valid[c] = mask[c];
          cam_data[c*PW +: PW] = exp_pix(seed, c, p);
          cam_sof[c] = sof && (p == 0);
          cam_eol[c] = (p == LW - 1);
        end
      end
      @(negedge clk);
      cam_valid = '0; cam_sof = '0; cam_eol = '0;
    end
  endtask

  task automatic check_row(input int base, input logic [7:0] seed, input bit sof);
    check("R5 row length", obs_cnt - base, ROW);
    if (obs_cnt - base == ROW) begin
      check("R5 contiguous", obs_cyc[base+ROW-1] - obs_cyc[base], ROW - 1);
      for (int i = 0; i < ROW; i++) begin
        check("R1 pixel order", obs_data[base+i], exp_pix(seed, i / LW, i % LW));
        check("R3 end of line", obs_eol[base+i], (i == ROW - 1) ? 1 : 0);
        check("R4 start of frame", obs_sof[base+i], (i == 0 && sof) ? 1 : 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", out_valid, 0);
    check("R8 reset err", cam_err, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      automatic logic [7:0] seed = VEC[v][15:8];
      automatic bit sof = VEC[v][7];
      automatic logic [N-1:0] first = VEC[v][N-1:0];
      automatic int base = obs_cnt;
      feed(first, seed, sof);
      if (first != ALL) begin
        repeat (6) @(negedge clk);
        check("R2 wait for all cameras", obs_cnt - base, 0);
        feed(~first & ALL, seed, sof);
      end
      repeat (ROW + 8) @(negedge clk);
      check_row(base, seed, sof);
    end

    // overflow on camera 1 only
    begin
      automatic int base = obs_cnt;
      feed(3'b010, 8'h00, 1'b0);
      feed(3'b010, 8'h04, 1'b0);
      check("R6 no flag before full", cam_err, 0);
      @(negedge clk);
      cam_valid = 3'b010; cam_data = '1;
      @(negedge clk);
      cam_valid = '0;
      check("R6 overflow flag", cam_err, 3'b010);
      repeat (5) @(negedge clk);
      check("R7 sticky", cam_err, 3'b010);
      check("R2 no row with one camera", obs_cnt - base, 0);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      @(negedge clk);
      check("R7 clear", cam_err, 0);
    end

    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset err again", cam_err, 0);
    check("R8 reset sof", out_sof, 0);
    check("R8 reset eol", out_eol, 0);
    begin
      automatic int base = obs_cnt;
      feed(ALL, 8'hA0, 1'b1);
      repeat (ROW + 8) @(negedge clk);
      check_row(base, 8'hA0, 1'b1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule